// File: doc/BRIEF.md
# Streaming Sparse Matrix-Vector Multiplier

This block computes y = A·x for a sparse matrix A of n rows and m columns. The matrix arrives in a compressed row-major form. A row-count stream carries one entry per row, giving that row's number of nonzeros. A nonzero stream carries one entry per nonzero, each a column index with a signed value. The dense vector x is streamed in first and held in a local buffer indexed by column. After that, the block walks every nonzero in one flat pass. It multiplies each value by the buffered x element for its column and adds the product to a running row sum.

A run starts with a one-cycle start pulse that carries the row and column counts. A down-counter, loaded from each row count, marks where a row ends. When the count runs out, the row sum leaves on the result stream. A row whose count is zero gives a zero result at once, without taking any nonzero. After the last result has been accepted, a one-cycle done pulse marks the end of the run. A stall on the result stream holds the whole pass, and no data is lost.

Top module: `spmv_stream`

## Requirements
- R1: After reset, y_valid, done, x_ready, len_ready and nz_ready are all low.
- R2: After start, x_ready is high until exactly cfg_cols vector elements have been accepted. Element k is stored as x[k]. x_ready is then low for the rest of the run.
- R3: No nonzero and no row count is accepted while the vector is still loading.
- R4: Each result is the exact signed sum of val × x[col] over that row's nonzeros, in two's complement on y_data.
- R5: A row count of zero gives a result of 0 and takes no nonzero. The total number of nonzeros accepted equals the sum of the row counts.
- R6: Exactly cfg_rows results are produced, in row order.
- R7: While y_valid is high and y_ready is low, y_valid stays high and y_data holds its value.
- R8: done is a single-cycle pulse. It is raised only after the last result has been accepted, and exactly once per run.
- R9: Take the 4×8 matrix with row counts 2,2,2,2, columns 0..7 and values 1,2,1,2,3,1,2,1. With x all ones, it yields 3,3,4,3.
- R10: Suppose every row count is nonzero, all inputs are valid and y_ready is held high. Then one nonzero is accepted every cycle, from the first to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run; only accepted when idle |
| cfg_cols | input | LEN_W | Vector length m, 1..MAX_COLS |
| cfg_rows | input | ROW_W | Row count n, 0..MAX_ROWS |
| x_valid | input | 1 | Vector element valid |
| x_ready | output | 1 | Vector element accepted |
| x_data | input | DATA_W | Signed vector element |
| len_valid | input | 1 | Row count valid |
| len_ready | output | 1 | Row count accepted |
| len_data | input | LEN_W | Nonzeros in the next row |
| nz_valid | input | 1 | Nonzero valid |
| nz_ready | output | 1 | Nonzero accepted |
| nz_col | input | COL_W | Column index of the nonzero |
| nz_val | input | DATA_W | Signed value of the nonzero |
| y_valid | output | 1 | Result valid |
| y_ready | input | 1 | Result accepted |
| y_data | output | ACC_W | Signed row result |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Suppose the row down-counter slips by one. Rows then merge or split. The next result carries the wrong sum, and the number of nonzeros taken before the done pulse no longer matches the total of the row counts. A stale accumulator shows up in the first result after a row boundary. A wrong buffer write shows up in the first result that reads that column. Runs mix zero-length rows, negative values, gaps in the input streams and a stalled result stream, so each of these faults reaches y_data within one row.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOADX = 2'd1,
      ST_RUN   = 2'd2
   } spmv_state_e;

   function automatic int min_acc_width(int data_w, int max_cols);
      return 2 * data_w + $clog2(max_cols + 1);
   endfunction
endpackage

// File: rtl/spmv_xbuf.sv
module spmv_xbuf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_idx) == g)) mem[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_idx) < DEPTH) rd_data = mem[rd_idx];
   end
endmodule

// File: rtl/spmv_mac.sv
module spmv_mac #(
   parameter int DATA_W      = 16,
   parameter int ACC_W       = 40,
   parameter bit SIGNED_MODE = 1'b1
) (
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] xval,
   input  logic              clear,
   input  logic              add_en,
   input  logic [ACC_W-1:0]  acc_in,
   output logic [ACC_W-1:0]  acc_out
);
   logic [ACC_W-1:0] prod_ext;

   if (SIGNED_MODE) begin : g_signed
      logic signed [2*DATA_W-1:0] prod;
      assign prod     = $signed(val) * $signed(xval);
      assign prod_ext = ACC_W'(prod);
   end else begin : g_unsigned
      logic [2*DATA_W-1:0] prod;
      assign prod     = val * xval;
      assign prod_ext = ACC_W'(prod);
   end

   always_comb begin
      acc_out = clear ? '0 : acc_in;
      if (add_en) acc_out = acc_out + prod_ext;
   end
endmodule

// File: rtl/spmv_stream.sv
module spmv_stream
   import spmv_pkg::*;
#(
   parameter int MAX_COLS    = 16,
   parameter int MAX_ROWS    = 16,
   parameter int DATA_W      = 16,
   parameter int ACC_W       = 40,
   parameter bit SIGNED_MODE = 1'b1,
   localparam int COL_W = $clog2(MAX_COLS),
   localparam int LEN_W = $clog2(MAX_COLS + 1),
   localparam int ROW_W = $clog2(MAX_ROWS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  cfg_cols,
   input  logic [ROW_W-1:0]  cfg_rows,
   input  logic              x_valid,
   output logic              x_ready,
   input  logic [DATA_W-1:0] x_data,
   input  logic              len_valid,
   output logic              len_ready,
   input  logic [LEN_W-1:0]  len_data,
   input  logic              nz_valid,
   output logic              nz_ready,
   input  logic [COL_W-1:0]  nz_col,
   input  logic [DATA_W-1:0] nz_val,
   output logic              y_valid,
   input  logic              y_ready,
   output logic [ACC_W-1:0]  y_data,
   output logic              done
);
   localparam int MIN_ACC = min_acc_width(DATA_W, MAX_COLS);

   if (MAX_COLS < 2) begin : g_bad_cols
      $error("spmv_stream: MAX_COLS must be at least 2");
   end
   if (MAX_ROWS < 1) begin : g_bad_rows
      $error("spmv_stream: MAX_ROWS must be at least 1");
   end
   if (ACC_W < MIN_ACC) begin : g_bad_acc
      $error("spmv_stream: ACC_W too narrow for exact sums");
   end

   spmv_state_e      state;
   logic [LEN_W-1:0] cols_r;
   logic [LEN_W-1:0] xcnt;
   logic [ROW_W-1:0] rows_left;
   logic [LEN_W-1:0] rem;
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_next;
   logic [DATA_W-1:0] xval;
   logic              y_valid_r;
   logic [ACC_W-1:0]  y_data_r;
   logic              done_r;

   logic x_fire, in_run, need_len, take_nz, len_ok, nz_ok, emit, out_free, step;

   assign x_ready = (state == ST_LOADX);
   assign x_fire  = x_ready && x_valid;

   always_comb begin
      in_run   = (state == ST_RUN) && (rows_left != '0);
      need_len = (rem == '0);
      take_nz  = need_len ? (len_data != '0) : 1'b1;
      len_ok   = need_len ? len_valid : 1'b1;
      nz_ok    = take_nz ? nz_valid : 1'b1;
      emit     = need_len ? (len_data <= LEN_W'(1)) : (rem == LEN_W'(1));
      out_free = !y_valid_r || y_ready;
      step      = in_run && len_ok && nz_ok && (!emit || out_free);
      len_ready = in_run && need_len && nz_ok && (!emit || out_free);
      nz_ready  = in_run && take_nz && len_ok && (!emit || out_free);
   end

   spmv_xbuf #(.DEPTH(MAX_COLS), .DATA_W(DATA_W)) i_xbuf (
      .clk     (clk),
      .wr_en   (x_fire),
      .wr_idx  (xcnt[COL_W-1:0]),
      .wr_data (x_data),
      .rd_idx  (nz_col),
      .rd_data (xval)
   );

   spmv_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SIGNED_MODE(SIGNED_MODE)) i_mac (
      .val     (nz_val),
      .xval    (xval),
      .clear   (need_len),
      .add_en  (take_nz),
      .acc_in  (acc),
      .acc_out (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cols_r    <= '0;
         xcnt      <= '0;
         rows_left <= '0;
         rem       <= '0;
         acc       <= '0;
         y_valid_r <= 1'b0;
         y_data_r  <= '0;
         done_r    <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (y_valid_r && y_ready) y_valid_r <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cols_r    <= cfg_cols;
                  rows_left <= cfg_rows;
                  xcnt      <= '0;
                  rem       <= '0;
                  state     <= (cfg_cols == '0) ? ST_RUN : ST_LOADX;
               end
            end
            ST_LOADX: begin
               if (x_fire) begin
                  xcnt <= xcnt + LEN_W'(1);
                  if (xcnt == cols_r - LEN_W'(1)) state <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (step) begin
                  acc <= acc_next;
                  if (need_len) rem <= take_nz ? len_data - LEN_W'(1) : '0;
                  else          rem <= rem - LEN_W'(1);
                  if (emit) begin
                     y_data_r  <= acc_next;
                     y_valid_r <= 1'b1;
                     rows_left <= rows_left - ROW_W'(1);
                  end
               end else if (rows_left == '0 && !y_valid_r) begin
                  done_r <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign y_valid = y_valid_r;
   assign y_data  = y_data_r;
   assign done    = done_r;
endmodule

// File: rtl/spmv_stream_chk.sv
module spmv_stream_chk #(
   parameter int ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             x_ready,
   input logic             len_ready,
   input logic             nz_ready,
   input logic             y_valid,
   input logic             y_ready,
   input logic [ACC_W-1:0] y_data,
   input logic             done
);
   p_y_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));

   p_load_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      x_ready |-> (!nz_ready && !len_ready));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!y_valid && !nz_ready && !len_ready));

   p_nz_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(x_ready) |-> !done);
endmodule

bind spmv_stream spmv_stream_chk #(.ACC_W(ACC_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .x_ready   (x_ready),
   .len_ready (len_ready),
   .nz_ready  (nz_ready),
   .y_valid   (y_valid),
   .y_ready   (y_ready),
   .y_data    (y_data),
   .done      (done)
);

// File: tb/test_spmv_stream.sv
module test_spmv_stream;
   localparam int MAX_COLS = 16;
   localparam int MAX_ROWS = 16;
   localparam int DATA_W   = 16;
   localparam int ACC_W    = 40;
   localparam int COL_W = $clog2(MAX_COLS);
   localparam int LEN_W = $clog2(MAX_COLS + 1);
   localparam int ROW_W = $clog2(MAX_ROWS + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [LEN_W-1:0] cfg_cols = '0;
   logic [ROW_W-1:0] cfg_rows = '0;
   logic x_valid = 1'b0, len_valid = 1'b0, nz_valid = 1'b0, y_ready = 1'b0;
   logic [DATA_W-1:0] x_data = '0, nz_val = '0;
   logic [LEN_W-1:0]  len_data = '0;
   logic [COL_W-1:0]  nz_col = '0;
   logic x_ready, len_ready, nz_ready, y_valid, done;
   logic [ACC_W-1:0] y_data;

   always #5 clk = ~clk;

   spmv_stream #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .DATA_W(DATA_W), .ACC_W(ACC_W))
   i_spmv_stream (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
      .len_valid(len_valid), .len_ready(len_ready), .len_data(len_data),
      .nz_valid(nz_valid), .nz_ready(nz_ready), .nz_col(nz_col), .nz_val(nz_val),
      .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .done(done)
   );

   int checks = 0, errors = 0;
   int xv [MAX_COLS];
   int lens [MAX_ROWS];
   int cidx [MAX_COLS*MAX_ROWS];
   int vals [MAX_COLS*MAX_ROWS];
   longint expq [$];
   longint got [MAX_ROWS];
   int nnz;
   bit gaps, bp;
   int m_xfire, m_nzfire, m_ycnt, m_done, m_first, m_last;

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drv_x(int n);
      int i = 0;
      while (i < n) begin
         @(negedge clk);
         x_valid = gaps ? ($urandom % 4 != 0) : 1'b1;
         x_data  = DATA_W'(xv[i]);
         #4;
         if (x_valid && x_ready) i++;
      end
      @(negedge clk); x_valid = 1'b0;
   endtask

   task automatic drv_len(int n);
      int i = 0;
      while (i < n) begin
         @(negedge clk);
         len_valid = gaps ? ($urandom % 4 != 0) : 1'b1;
         len_data  = LEN_W'(lens[i]);
         #4;
         if (len_valid && len_ready) i++;
      end
      @(negedge clk); len_valid = 1'b0;
   endtask

   task automatic drv_nz(int n);
      int i = 0;
      while (i < n) begin
         @(negedge clk);
         nz_valid = gaps ? ($urandom % 4 != 0) : 1'b1;
         nz_col   = COL_W'(cidx[i]);
         nz_val   = DATA_W'(vals[i]);
         #4;
         if (nz_valid && nz_ready) i++;
      end
      @(negedge clk); nz_valid = 1'b0;
   endtask

   task automatic monitor(int nc, int nr);
      bit held = 1'b0;
      longint hval = 0;
      int cyc = 0;
      m_xfire = 0; m_nzfire = 0; m_ycnt = 0; m_done = 0; m_first = -1; m_last = -1;
      while (m_done == 0) begin
         @(negedge clk);
         y_ready = bp ? ($urandom % 3 != 0) : 1'b1;
         #4;
         cyc++;
         if (held) begin
            chk(y_valid && longint'($signed(y_data)) == hval, "R7 stall hold",
                longint'($signed(y_data)), hval);
         end
         if (nz_valid && nz_ready) begin
            if (m_xfire < nc) chk(1'b0, "R3 nonzero taken during load", m_xfire, nc);
            if (m_first < 0) m_first = cyc;
            m_last = cyc;
            m_nzfire++;
         end
         if (len_valid && len_ready && m_xfire < nc)
            chk(1'b0, "R3 row count taken during load", m_xfire, nc);
         if (x_valid && x_ready) m_xfire++;
         held = y_valid && !y_ready;
         hval = longint'($signed(y_data));
         if (y_valid && y_ready) begin
            longint e = (expq.size() > 0) ? expq.pop_front() : 64'hDEAD;
            chk(longint'($signed(y_data)) == e, "R4 R6 row result",
                longint'($signed(y_data)), e);
            if (m_ycnt < MAX_ROWS) got[m_ycnt] = longint'($signed(y_data));
            m_ycnt++;
         end
         if (done) begin
            m_done++;
            chk(m_ycnt == nr && !y_valid, "R8 done after last result", m_ycnt, nr);
         end
      end
      @(negedge clk); #4;
      chk(!done, "R8 done single cycle", done, 0);
   endtask

   task automatic run(int nc, int nr);
      int p = 0;
      nnz = 0;
      expq.delete();
      for (int r = 0; r < nr; r++) begin
         longint s = 0;
         for (int k = 0; k < lens[r]; k++) begin
            s += longint'(vals[p]) * longint'(xv[cidx[p]]);
            p++;
         end
         expq.push_back(s);
      end
      nnz = p;
      @(negedge clk);
      start = 1'b1; cfg_cols = LEN_W'(nc); cfg_rows = ROW_W'(nr);
      @(negedge clk);
      start = 1'b0;
      fork
         drv_x(nc);
         drv_len(nr);
         drv_nz(nnz);
         monitor(nc, nr);
      join
      chk(m_xfire == nc, "R2 vector elements taken", m_xfire, nc);
      chk(!x_ready, "R2 x_ready low after load", x_ready, 0);
      chk(m_nzfire == nnz, "R5 nonzeros taken", m_nzfire, nnz);
      chk(m_ycnt == nr && expq.size() == 0, "R6 result count", m_ycnt, nr);
      chk(m_done == 1, "R8 one done pulse", m_done, 1);
   endtask

   task automatic rand_matrix(int nc, int nr, int maxlen, bit allow_zero);
      int p = 0;
      for (int c = 0; c < nc; c++) xv[c] = $signed($urandom % 2001) - 1000;
      for (int r = 0; r < nr; r++) begin
         lens[r] = allow_zero ? int'($urandom % (maxlen + 1)) : 1 + int'($urandom % maxlen);
         for (int k = 0; k < lens[r]; k++) begin
            cidx[p] = int'($urandom % nc);
            vals[p] = $signed($urandom % 65536) - 32768;
            p++;
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #4;
      chk(!y_valid && !done && !x_ready && !len_ready && !nz_ready, "R1 reset outputs",
          {y_valid, done, x_ready, len_ready, nz_ready}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R9: example matrix with x all ones, gaps and stalls off
      gaps = 1'b0; bp = 1'b0;
      for (int c = 0; c < 8; c++) begin xv[c] = 1; cidx[c] = c; end
      for (int r = 0; r < 4; r++) lens[r] = 2;
      vals[0] = 1; vals[1] = 2; vals[2] = 1; vals[3] = 2;
      vals[4] = 3; vals[5] = 1; vals[6] = 2; vals[7] = 1;
      run(8, 4);
      chk(got[0] == 3 && got[1] == 3 && got[2] == 4 && got[3] == 3, "R9 example result",
          got[2], 4);

      // R10: full throughput, no zero rows, no gaps
      rand_matrix(8, 6, 4, 1'b0);
      run(8, 6);
      chk(m_last - m_first == nnz - 1, "R10 one nonzero per cycle", m_last - m_first, nnz - 1);

      // R5: zero-length rows, negative values, gaps and stalls
      gaps = 1'b1; bp = 1'b1;
      rand_matrix(8, 6, 3, 1'b1);
      lens[0] = 0; lens[5] = 0;
      begin
         int p = 0;
         for (int r = 0; r < 6; r++)
            for (int k = 0; k < lens[r]; k++) begin
               cidx[p] = int'($urandom % 8); vals[p] = $signed($urandom % 2001) - 1000; p++;
            end
      end
      run(8, 6);
      chk(got[0] == 0 && got[5] == 0, "R5 empty row gives zero", got[0], 0);

      // R4: full size, extreme values accumulate exactly
      for (int c = 0; c < MAX_COLS; c++) xv[c] = -32768;
      for (int r = 0; r < MAX_ROWS; r++) lens[r] = MAX_COLS;
      for (int p = 0; p < MAX_COLS*MAX_ROWS; p++) begin cidx[p] = p % MAX_COLS; vals[p] = -32768; end
      run(MAX_COLS, MAX_ROWS);
      chk(got[MAX_ROWS-1] == longint'(MAX_COLS) * 1073741824, "R4 full-row extreme sum",
          got[MAX_ROWS-1], longint'(MAX_COLS) * 1073741824);

      // R6: random full-size run with stalls
      rand_matrix(MAX_COLS, MAX_ROWS, 5, 1'b1);
      run(MAX_COLS, MAX_ROWS);

      // R8: a run with no rows ends with done alone
      for (int c = 0; c < 4; c++) xv[c] = c;
      run(4, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule